// File: doc/BRIEF.md
# Prime-Period Nonlinear Counter Bank

This block is a bank of sixteen short shift registers that together act as a residue-style counter. Each register runs through a cycle whose length is a prime number, and no two registers share a prime. Because the primes are pairwise coprime, the combined 16-register state repeats only after the product of all sixteen lengths. The bank sits in front of a diffusion stage. It delivers one bit per register, sixteen bits in all, on every clock. It does not drive the cipher output directly.

Each register shifts toward its most significant bit. A parity of fixed taps is fed into bit 0. A full-width equality term makes the step nonlinear and cuts a maximal-length sequence down to the prime length. Every register moves through one of five named next-state selections on each clock:
- load: the external state is written.
- hold: the counter is idle.
- rescue: an all-zero register is re-seeded.
- wrap: the terminal state of the prime cycle jumps back to the seed.
- shift: the ordinary feedback step.

Priority runs from load, through hold, rescue and wrap, down to shift. Key/IV seeding uses the one-cycle load port. In unkeyed hashing, a message byte enters the bank by toggling the feedback bits of the registers.

Top module: `prime_ctr_bank`

## Requirements
- R1: Register i (i = 0..15) has width 5+(i mod 8), so reg 0 is 5 bits and reg 15 is 12 bits. `ctr_bits[i]` is bit W-1 of register i in every cycle. In `load_state`, register 0 occupies the lowest bits, and each following register sits directly above the one before it (register i starts at the sum of the widths of registers 0..i-1).
- R2: While `rst_n` is low, every register is set to the seed pattern. In the seed only bit 0 is 1.
- R3: On a plain step, a register with state s becomes {s[W-2:0], f}. Here f is the XOR of the bits of s under the tap mask for its width: 5:0x014, 6:0x030, 7:0x060, 8:0x0B8, 9:0x110, 10:0x240, 11:0x500, 12:0x829.
- R4: Starting from the seed, register i first returns to the seed after exactly P_i steps. P for registers 0..7 is 31, 61, 127, 251, 509, 1021, 2039, 4093. P for registers 8..15 is 29, 59, 113, 241, 503, 1019, 2029, 4091.
- R5: A register that is all zero when a step occurs becomes the seed pattern on that step.
- R6: With `step_en` and `load_en` both low, every register keeps its state.
- R7: With `load_en` high, the whole concatenated state takes `load_state` in one cycle. This holds regardless of `step_en`, `msg_valid` and `msg_byte`.
- R8: On a step with `msg_valid` high, `msg_byte[j]` is XORed into the new bit 0 of registers j and j+8. This applies to the shift, wrap and rescue selections alike.
- R9: With `msg_valid` low, `msg_byte` has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance all registers this cycle |
| load_en | input | 1 | Write full state from `load_state` |
| load_state | input | 136 | Concatenated register seeds, register 0 at bit 0 |
| msg_valid | input | 1 | Qualifies `msg_byte` for injection |
| msg_byte | input | 8 | Hash-mode message byte |
| ctr_bits | output | 16 | Most significant bit of each register |

## Verification
The bench builds the block with its default bank: widths of 5 to 12 bits and primes no larger than 4093. At that size one run of about 4100 cycles covers a complete period of every register at once. Twelve consecutive output bits are enough to rebuild the whole state of any register. The bench can therefore confirm the exact first-return step of each register. It also compares every output bit of every register against an arithmetic model across the full period.

// File: rtl/pnc_pkg.sv
package pnc_pkg;

    localparam int NREG   = 16;
    localparam int BYTE_W = 8;
    localparam int MAXW   = 12;

    localparam int REG_W [NREG] = '{5, 6, 7, 8, 9, 10, 11, 12,
                                    5, 6, 7, 8, 9, 10, 11, 12};

    localparam int REG_P [NREG] = '{31, 61, 127, 251, 509, 1021, 2039, 4093,
                                    29, 59, 113, 241, 503, 1019, 2029, 4091};

    localparam logic [MAXW-1:0] REG_TAP [NREG] = '{
        12'h014, 12'h030, 12'h060, 12'h0B8, 12'h110, 12'h240, 12'h500, 12'h829,
        12'h014, 12'h030, 12'h060, 12'h0B8, 12'h110, 12'h240, 12'h500, 12'h829};

    localparam logic [MAXW-1:0] SEED_PAT = 12'h001;

    typedef enum logic [2:0] {
        NX_HOLD,
        NX_LOAD,
        NX_RESCUE,
        NX_WRAP,
        NX_SHIFT
    } nx_sel_e;

    function automatic int reg_off(input int idx);
        int acc;
        acc = 0;
        for (int k = 0; k < idx; k++) acc += REG_W[k];
        return acc;
    endfunction

    localparam int STATE_W = reg_off(NREG);

    function automatic logic [MAXW-1:0] width_mask(input int w);
        return {MAXW{1'b1}} >> (MAXW - w);
    endfunction

    function automatic logic [MAXW-1:0] plain_step(input logic [MAXW-1:0] s,
                                                   input int w,
                                                   input logic [MAXW-1:0] taps);
        logic fbit;
        fbit = ^(s & taps);
        return ((s << 1) | {{(MAXW-1){1'b0}}, fbit}) & width_mask(w);
    endfunction

    // State reached after p-1 plain steps from the seed: the last state of the prime cycle.
    function automatic logic [MAXW-1:0] wrap_point(input int w,
                                                   input logic [MAXW-1:0] taps,
                                                   input int p,
                                                   input logic [MAXW-1:0] seed);
        logic [MAXW-1:0] s;
        s = seed;
        for (int k = 0; k < p - 1; k++) s = plain_step(s, w, taps);
        return s;
    endfunction

endpackage

// File: rtl/pnc_inject.sv
module pnc_inject
    import pnc_pkg::*;
(
    input  logic              msg_valid,
    input  logic [BYTE_W-1:0] msg_byte,
    output logic [NREG-1:0]   flips
);

    for (genvar i = 0; i < NREG; i++) begin : g_map
        always_comb flips[i] = msg_valid & msg_byte[i % BYTE_W];
    end

endmodule

// File: rtl/pnc_cell.sv
module pnc_cell
    import pnc_pkg::*;
#(
    parameter int              W     = 5,
    parameter logic [MAXW-1:0] TAPS  = 12'h014,
    parameter int              PRIME = 31,
    parameter logic [MAXW-1:0] SEED  = 12'h001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         inj,
    output logic         msb
);

    localparam logic [MAXW-1:0] TERM_FULL = wrap_point(W, TAPS, PRIME, SEED);
    localparam logic [W-1:0]    TERM      = TERM_FULL[W-1:0];
    localparam logic [W-1:0]    SEED_W    = SEED[W-1:0];
    localparam logic [W-1:0]    TAP_W     = TAPS[W-1:0];

    logic [W-1:0] st;
    logic [W-1:0] st_nx;
    logic [W-1:0] shifted;
    logic         fbit;
    nx_sel_e      sel;

    always_comb begin
        fbit    = (^(st & TAP_W)) ^ inj;
        shifted = {st[W-2:0], fbit};
    end

    always_comb begin
        if (load_en)           sel = NX_LOAD;
        else if (!step_en)     sel = NX_HOLD;
        else if (st == '0)     sel = NX_RESCUE;
        else if (st == TERM)   sel = NX_WRAP;
        else                   sel = NX_SHIFT;
    end

    always_comb begin
        unique case (sel)
            NX_LOAD:   st_nx = load_val;
            NX_HOLD:   st_nx = st;
            NX_RESCUE: st_nx = SEED_W ^ W'(inj);
            NX_WRAP:   st_nx = SEED_W ^ W'(inj);
            NX_SHIFT:  st_nx = shifted;
            default:   st_nx = st;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SEED_W;
        else        st <= st_nx;
    end

    always_comb msb = st[W-1];

    assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> st == $past(load_val));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !step_en) |=> $stable(st));

    assert_zero_rescue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en && !inj && st == '0) |=> st == SEED_W);

    assert_prime_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en && !inj && st == TERM) |=> st == SEED_W);

    assert_shift_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en && st != '0 && st != TERM) |=> st[W-1:1] == $past(st[W-2:0]));

endmodule

// File: rtl/prime_ctr_bank.sv
module prime_ctr_bank
    import pnc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_en,
    input  logic               load_en,
    input  logic [STATE_W-1:0] load_state,
    input  logic               msg_valid,
    input  logic [BYTE_W-1:0]  msg_byte,
    output logic [NREG-1:0]    ctr_bits
);

    logic [NREG-1:0] flips;

    pnc_inject u_inject (
        .msg_valid (msg_valid),
        .msg_byte  (msg_byte),
        .flips     (flips)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam int RW  = REG_W[i];
        localparam int OFF = reg_off(i);

        pnc_cell #(
            .W     (RW),
            .TAPS  (REG_TAP[i]),
            .PRIME (REG_P[i]),
            .SEED  (SEED_PAT)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .step_en  (step_en),
            .load_en  (load_en),
            .load_val (load_state[OFF +: RW]),
            .inj      (flips[i]),
            .msb      (ctr_bits[i])
        );
    end

    assert_quiet_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid |-> flips == '0);

    assert_pair_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flips[NREG/2-1:0] == flips[NREG-1:NREG/2]);

endmodule

// File: tb/tb_prime_ctr_bank.sv
module tb_prime_ctr_bank;

    localparam int NR = 16;
    localparam int SW = 136;
    localparam int HN = 4200;

    localparam int BW [NR] = '{5, 6, 7, 8, 9, 10, 11, 12, 5, 6, 7, 8, 9, 10, 11, 12};
    localparam int BP [NR] = '{31, 61, 127, 251, 509, 1021, 2039, 4093,
                               29, 59, 113, 241, 503, 1019, 2029, 4091};
    localparam logic [11:0] BT [NR] = '{12'h014, 12'h030, 12'h060, 12'h0B8, 12'h110, 12'h240, 12'h500, 12'h829,
                                        12'h014, 12'h030, 12'h060, 12'h0B8, 12'h110, 12'h240, 12'h500, 12'h829};

    logic          clk = 1'b0;
    logic          rst_n;
    logic          step_en;
    logic          load_en;
    logic [SW-1:0] load_state;
    logic          msg_valid;
    logic [7:0]    msg_byte;
    logic [15:0]   ctr_bits;

    int checks = 0;
    int errors = 0;
    logic [15:0] hist [0:HN-1];

    always #5 clk = ~clk;

    prime_ctr_bank dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .load_en    (load_en),
        .load_state (load_state),
        .msg_valid  (msg_valid),
        .msg_byte   (msg_byte),
        .ctr_bits   (ctr_bits)
    );

    function automatic logic [11:0] msk(input int r);
        return 12'hFFF >> (12 - BW[r]);
    endfunction

    function automatic int boff(input int r);
        int a;
        a = 0;
        for (int k = 0; k < r; k++) a += BW[k];
        return a;
    endfunction

    function automatic logic [11:0] nxt(input int r, input logic [11:0] s);
        logic f;
        f = ^(s & BT[r]);
        return ((s << 1) | {11'b0, f}) & msk(r);
    endfunction

    function automatic logic [11:0] pat(input int r, input int kind);
        logic [11:0] v;
        if (kind == 0)      v = 12'h001;
        else if (kind == 1) v = 12'h000;
        else begin
            v = (12'h9C6 ^ 12'(r * 37)) & msk(r);
            if (v == 12'h000) v = 12'h001;
        end
        return v;
    endfunction

    function automatic logic [SW-1:0] pack(input int kind);
        logic [SW-1:0] p;
        logic [11:0]   v;
        p = '0;
        for (int r = 0; r < NR; r++) begin
            v = pat(r, kind);
            for (int b = 0; b < BW[r]; b++) p[boff(r) + b] = v[b];
        end
        return p;
    endfunction

    // Rebuild a register's state at time t from W successive top bits.
    function automatic logic [11:0] state_at(input int r, input int t);
        logic [11:0] s;
        s = '0;
        for (int k = 0; k < BW[r]; k++) s[BW[r] - 1 - k] = hist[t + k][r];
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic record(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            hist[k] = ctr_bits;
            load_en   = 1'b0;
            msg_valid = 1'b0;
            step_en   = 1'b1;
        end
        step_en = 1'b0;
    endtask

    task automatic load_kind(input int kind, input bit st, input bit mv, input logic [7:0] mb);
        @(negedge clk);
        load_en    = 1'b1;
        load_state = pack(kind);
        step_en    = st;
        msg_valid  = mv;
        msg_byte   = mb;
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int bad;
        logic [15:0] first;
        logic [7:0]  mb;
        rst_n = 1'b0; step_en = 1'b0; load_en = 1'b0;
        load_state = '0; msg_valid = 1'b0; msg_byte = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 / R1: reset contents and output bit position
        record(13);
        check(hist[0] == 16'h0000, "R1", "top bits after reset", 32'(hist[0]), 0);
        bad = 0;
        for (int r = 0; r < NR; r++) if (state_at(r, 0) != 12'h001) bad++;
        check(bad == 0, "R2", "registers not at seed after reset", bad, 0);

        // R7: load beats step and message injection
        load_kind(0, 1'b1, 1'b1, 8'hFF);
        record(4110);
        bad = 0;
        for (int r = 0; r < NR; r++) if (state_at(r, 0) != 12'h001) bad++;
        check(bad == 0, "R7", "registers not loaded under step+msg", bad, 0);

        // R4: first return to the seed is exactly the prime
        for (int r = 0; r < NR; r++) begin
            int ret;
            ret = 0;
            for (int t = 1; t <= BP[r] && ret == 0; t++)
                if (state_at(r, t) == 12'h001) ret = t;
            check(ret == BP[r], "R4", $sformatf("period of reg %0d", r), ret, BP[r]);
        end

        // R3: full bit stream against the tap model with prime wrap
        for (int r = 0; r < NR; r++) begin
            logic [11:0] m;
            int mism;
            m = 12'h001;
            mism = 0;
            for (int t = 0; t < 4100; t++) begin
                if (hist[t][r] != m[BW[r] - 1]) mism++;
                m = (((t + 1) % BP[r]) == 0) ? 12'h001 : nxt(r, m);
            end
            check(mism == 0, "R3", $sformatf("stream mismatches reg %0d", r), mism, 0);
        end

        // R6: idle cycles keep the loaded pattern
        load_kind(2, 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        load_en = 1'b0;
        first = ctr_bits;
        bad = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (ctr_bits != first) bad++;
        end
        check(bad == 0, "R6", "outputs moved while idle", bad, 0);
        record(13);
        bad = 0;
        for (int r = 0; r < NR; r++) if (state_at(r, 0) != pat(r, 2)) bad++;
        check(bad == 0, "R6", "state changed while idle", bad, 0);

        // R5: all-zero registers are re-seeded on the next step
        load_kind(1, 1'b0, 1'b0, 8'h00);
        record(14);
        bad = 0;
        for (int r = 0; r < NR; r++)
            if (state_at(r, 0) != 12'h000 || state_at(r, 1) != 12'h001) bad++;
        check(bad == 0, "R5", "zero state not rescued", bad, 0);

        // R8: message byte toggles feedback of register pairs
        mb = 8'hA5;
        load_kind(0, 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        load_en = 1'b0; step_en = 1'b1; msg_valid = 1'b1; msg_byte = mb;
        record(13);
        bad = 0;
        for (int r = 0; r < NR; r++)
            if (state_at(r, 0) != (nxt(r, 12'h001) ^ {11'b0, mb[r % 8]})) bad++;
        check(bad == 0, "R8", "injected byte not seen in pairs", bad, 0);

        // R9: byte without valid is ignored
        load_kind(0, 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        load_en = 1'b0; step_en = 1'b1; msg_valid = 1'b0; msg_byte = 8'hFF;
        record(13);
        bad = 0;
        for (int r = 0; r < NR; r++) if (state_at(r, 0) != nxt(r, 12'h001)) bad++;
        check(bad == 0, "R9", "byte leaked without valid", bad, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule